// File: doc/BRIEF.md
# Serial Port Register and Interrupt Controller

This block is the software-facing side of a byte-oriented serial port. A processor reaches it through a 32-bit register bus. Each access carries a word index and four byte enables. Behind the registers sit two byte queues. The transmit queue is filled by register writes and emptied by a downstream byte sink over a valid/ready pair. The receive queue is filled by an upstream byte source that strobes one byte at a time, and it is emptied by register reads.

Registers are big-endian words, and each register keeps only the bits of its fixed writable mask. Two sticky status flags follow the queue levels. A single level interrupt is the OR of the enabled flags. Software clears the flags by writing zeros into them, so any bit written as one is left alone. A FIFO control register can flush either queue, but only when its enable bit is set in the same write. The serial bit framing, baud timing and DMA are handled elsewhere.

Top module: `serial_port_csr`

## Requirements
- R1: The register is selected by the word index `bus_idx`: line control 0, line status 1, interrupt enable 2, interrupt flags 3, FIFO control 4, baud divisor 5, transmit data 8, receive data 12. Transmit data and every unmapped index read as zero. A read result appears on `bus_rdata` on the clock edge that ends the access, and it holds until the next read.
- R2: While `rst` is high, both queues empty and the line status, interrupt enable, interrupt flag and FIFO control registers become 0. Line control becomes 0x40000000 and the baud divisor becomes 0x03FF0000.
- R3: Byte enable bit i covers data bits 8i+7:8i. A write keeps only the enabled lanes, and only within the register's mask: line control 0xE17F0000, interrupt enable 0x000F0000, FIFO control 0x001F0000, baud divisor 0x03FF0000. Writes to line status and to receive data change nothing.
- R4: A write to the interrupt flag register ANDs each enabled lane into the current value, under the mask 0x00070000. A zero clears a flag and a one leaves it as it is.
- R5: Flag bit 16 (receive data ready) is set on every edge at which the receive queue held data. Flag bit 17 (transmit empty) is set on every edge at which the transmit queue was empty. Both flags stay set until software clears them.
- R6: `irq` is high exactly when the interrupt flags AND the interrupt enables (bit 16 receive, bit 17 transmit, bit 18 error, bit 19 DMA) is nonzero. It changes on the same edge as those registers.
- R7: In FIFO control, bit 16 enables a flush, bit 17 flushes the receive queue and bit 18 flushes the transmit queue. A queue is flushed by a write only when the written value has bit 16 set together with that queue's bit. The stored bits remain readable.
- R8: A transmit-data write pushes `bus_wdata[7:0]` only when `bus_be[0]` is set. `tx_valid` is high while the transmit queue holds data, and `tx_data` shows the oldest byte. That byte is removed on an edge where `tx_ready` is high.
- R9: A receive-data read with `bus_be[3]` set on a non-empty queue returns the oldest byte in bits 31:24, with zeros below, and removes exactly one byte. With `bus_be[3]` clear, or on an empty queue, the read returns zero and removes nothing.
- R10: Each queue holds 16 bytes. A push to a full transmit queue is dropped and sets line status bit 17. A received byte that arrives at a full receive queue is dropped and sets line status bit 16. Both bits are sticky and read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 4 | Word index of the register |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_ready | input | 1 | Sink takes the byte on this edge |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte strobe |
| irq | output | 1 | Level interrupt |

## Verification
Each queue has only one edge of latency, so a wrong pointer or count shows on `tx_valid` or `tx_data` within a cycle. The same error shows on the next receive-data read, as a missing, repeated or out-of-order byte. A flag register that is wrong is visible at once on `irq` whenever its enable is set. Otherwise it shows on the next read of the flag register. A wrong line status or control bit stays hidden until that register is read, so the bench reads every register after each stimulus group and compares a behavioural queue model against the ports on every clock.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DW = 32;

  localparam int IX_LINE = 0;
  localparam int IX_STAT = 1;
  localparam int IX_IEN  = 2;
  localparam int IX_IFLG = 3;
  localparam int IX_FCTL = 4;
  localparam int IX_BAUD = 5;
  localparam int IX_TXD  = 8;
  localparam int IX_RXD  = 12;

  localparam logic [DW-1:0] MSK_LINE = 32'hE17F_0000;
  localparam logic [DW-1:0] MSK_IEN  = 32'h000F_0000;
  localparam logic [DW-1:0] MSK_IFLG = 32'h0007_0000;
  localparam logic [DW-1:0] MSK_FCTL = 32'h001F_0000;
  localparam logic [DW-1:0] MSK_BAUD = 32'h03FF_0000;

  localparam logic [DW-1:0] RST_LINE = 32'h4000_0000;
  localparam logic [DW-1:0] RST_BAUD = 32'h03FF_0000;

  localparam int B_RXRDY = 16;
  localparam int B_TXEMP = 17;
  localparam int B_RXOVR = 16;
  localparam int B_TXOVF = 17;
  localparam int B_FLEN  = 16;
  localparam int B_FLRX  = 17;
  localparam int B_FLTX  = 18;

  function automatic logic [DW-1:0] lane_bits(input logic [DW/8-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < DW/8; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          take, give;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign take  = push && !full;
  assign give  = pop && !empty;
  assign dout  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (take && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (take) wr_ptr <= bump(wr_ptr);
      if (give) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(take) - CW'(give);
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> (count == $past(count)));
  a_r10_bounded: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);
endmodule

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
  import sio_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW/8-1:0]  be,
  input  logic [DW-1:0]    wdata,
  input  logic             rx_nonempty,
  input  logic             tx_empty,
  input  logic             rx_drop,
  input  logic             tx_drop,
  output logic [DW-1:0]    line_q,
  output logic [DW-1:0]    stat_q,
  output logic [DW-1:0]    ien_q,
  output logic [DW-1:0]    iflg_q,
  output logic [DW-1:0]    fctl_q,
  output logic [DW-1:0]    baud_q,
  output logic             rx_flush,
  output logic             tx_flush,
  output logic             irq
);
  logic [DW-1:0] lm;
  logic [DW-1:0] line_d, stat_d, ien_d, iflg_d, fctl_d, baud_d;
  logic          irq_d;
  logic          wr_fctl;

  assign lm      = lane_bits(be);
  assign wr_fctl = wr_en && (idx == IDX_W'(IX_FCTL));

  always_comb begin
    line_d = line_q;
    stat_d = stat_q;
    ien_d  = ien_q;
    iflg_d = iflg_q;
    fctl_d = fctl_q;
    baud_d = baud_q;
    if (wr_en) begin
      if (idx == IDX_W'(IX_LINE)) line_d = MSK_LINE & ((line_q & ~lm) | (wdata & lm));
      if (idx == IDX_W'(IX_IEN))  ien_d  = MSK_IEN  & ((ien_q  & ~lm) | (wdata & lm));
      if (idx == IDX_W'(IX_IFLG)) iflg_d = MSK_IFLG & ((iflg_q & ~lm) | (iflg_q & wdata & lm));
      if (idx == IDX_W'(IX_FCTL)) fctl_d = MSK_FCTL & ((fctl_q & ~lm) | (wdata & lm));
      if (idx == IDX_W'(IX_BAUD)) baud_d = MSK_BAUD & ((baud_q & ~lm) | (wdata & lm));
    end
    if (rx_nonempty) iflg_d[B_RXRDY] = 1'b1;
    if (tx_empty)    iflg_d[B_TXEMP] = 1'b1;
    if (rx_drop)     stat_d[B_RXOVR] = 1'b1;
    if (tx_drop)     stat_d[B_TXOVF] = 1'b1;
    irq_d = |(iflg_d & ien_d);
  end

  assign rx_flush = wr_fctl && fctl_d[B_FLEN] && fctl_d[B_FLRX];
  assign tx_flush = wr_fctl && fctl_d[B_FLEN] && fctl_d[B_FLTX];

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= RST_LINE;
      stat_q <= '0;
      ien_q  <= '0;
      iflg_q <= '0;
      fctl_q <= '0;
      baud_q <= RST_BAUD;
      irq    <= 1'b0;
    end else begin
      line_q <= line_d;
      stat_q <= stat_d;
      ien_q  <= ien_d;
      iflg_q <= iflg_d;
      fctl_q <= fctl_d;
      baud_q <= baud_d;
      irq    <= irq_d;
    end
  end

  a_r6_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == |(iflg_q & ien_q));
  a_r5_rx_flag: assert property (@(posedge clk) disable iff (rst)
    rx_nonempty |=> iflg_q[B_RXRDY]);
  a_r5_tx_flag: assert property (@(posedge clk) disable iff (rst)
    tx_empty |=> iflg_q[B_TXEMP]);
  a_r4_write_never_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(IX_IFLG) && !rx_nonempty && !tx_empty) |=>
      ((iflg_q & ~$past(iflg_q)) == '0));
  a_r10_status_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/serial_port_csr.sv
module serial_port_csr
  import sio_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  output logic             irq
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic          wr_en, rd_en;
  logic          tx_push, tx_pop, rx_pop;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0]    rx_head;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          rx_flush, tx_flush;
  logic [DW-1:0] line_q, stat_q, ien_q, iflg_q, fctl_q, baud_q;
  logic [DW-1:0] rd_val;

  assign wr_en   = bus_sel && bus_we;
  assign rd_en   = bus_sel && !bus_we;
  assign tx_push = wr_en && (bus_idx == IDX_W'(IX_TXD)) && bus_be[0];
  assign rx_pop  = rd_en && (bus_idx == IDX_W'(IX_RXD)) && bus_be[3];
  assign tx_pop  = tx_ready;
  assign tx_valid = !tx_empty;

  sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_flush),
    .push(tx_push), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_data),
    .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_flush),
    .push(rx_valid), .din(rx_data),
    .pop(rx_pop), .dout(rx_head),
    .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  sio_ctrl_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .idx(bus_idx), .be(bus_be), .wdata(bus_wdata),
    .rx_nonempty(!rx_empty), .tx_empty(tx_empty),
    .rx_drop(rx_valid && rx_full), .tx_drop(tx_push && tx_full),
    .line_q(line_q), .stat_q(stat_q), .ien_q(ien_q), .iflg_q(iflg_q),
    .fctl_q(fctl_q), .baud_q(baud_q),
    .rx_flush(rx_flush), .tx_flush(tx_flush), .irq(irq)
  );

  always_comb begin
    rd_val = '0;
    if      (bus_idx == IDX_W'(IX_LINE)) rd_val = line_q;
    else if (bus_idx == IDX_W'(IX_STAT)) rd_val = stat_q;
    else if (bus_idx == IDX_W'(IX_IEN))  rd_val = ien_q;
    else if (bus_idx == IDX_W'(IX_IFLG)) rd_val = iflg_q;
    else if (bus_idx == IDX_W'(IX_FCTL)) rd_val = fctl_q;
    else if (bus_idx == IDX_W'(IX_BAUD)) rd_val = baud_q;
    else if (bus_idx == IDX_W'(IX_RXD) && bus_be[3] && !rx_empty)
      rd_val = {rx_head, 24'h0};
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_val;
  end

  a_r9_single_pop: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && !rx_empty && !rx_valid && !rx_flush) |=> (rx_cnt == $past(rx_cnt) - CW'(1)));
  a_r9_no_pop_without_lane: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !bus_be[3] && !rx_valid && !rx_flush) |=> (rx_cnt == $past(rx_cnt)));
  a_r8_lane_gates_push: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_idx == IDX_W'(IX_TXD) && !bus_be[0] && !tx_ready && !tx_flush) |=>
      (tx_cnt == $past(tx_cnt)));
endmodule

// File: tb/test_serial_port_csr.sv
`timescale 1ns/1ps
module test_serial_port_csr;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_idx = '0, bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data, rx_data = '0;
  logic        tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, irq;

  int vectors = 0;
  int misses  = 0;
  bit run     = 1'b0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  serial_port_csr i_serial_port_csr (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .irq(irq)
  );

  // behavioural reference
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  logic [31:0] m_line, m_stat, m_ien, m_iflg, m_fctl, m_baud, m_rdata;
  logic        m_irq;

  function automatic logic [31:0] lanes(input logic [3:0] be);
    logic [31:0] r = 32'h0;
    if (be[0]) r = r | 32'h0000_00FF;
    if (be[1]) r = r | 32'h0000_FF00;
    if (be[2]) r = r | 32'h00FF_0000;
    if (be[3]) r = r | 32'hFF00_0000;
    return r;
  endfunction

  task automatic model_step();
    logic [31:0] lm, rv;
    bit txe0, rxne0, txf0, rxf0, tpush, tpop, rpop, tclr, rclr;
    int ix;
    if (rst) begin
      txq.delete(); rxq.delete();
      m_line = 32'h4000_0000; m_baud = 32'h03FF_0000;
      m_stat = 0; m_ien = 0; m_iflg = 0; m_fctl = 0; m_rdata = 0; m_irq = 0;
      return;
    end
    ix = int'(bus_idx); lm = lanes(bus_be);
    txe0 = (txq.size() == 0); rxne0 = (rxq.size() != 0);
    txf0 = (txq.size() == DEPTH); rxf0 = (rxq.size() == DEPTH);
    tpush = 0; rpop = 0; tclr = 0; rclr = 0;
    tpop = !txe0 && tx_ready;
    if (bus_sel && !bus_we) begin
      case (ix)
        0: rv = m_line;  1: rv = m_stat;  2: rv = m_ien;
        3: rv = m_iflg;  4: rv = m_fctl;  5: rv = m_baud;
        12: begin
          rv = 0;
          if (bus_be[3] && rxne0) begin rv = {rxq[0], 24'h0}; rpop = 1; end
        end
        default: rv = 0;
      endcase
      m_rdata = rv;
    end
    if (bus_sel && bus_we) begin
      case (ix)
        0: m_line = 32'hE17F_0000 & ((m_line & ~lm) | (bus_wdata & lm));
        2: m_ien  = 32'h000F_0000 & ((m_ien & ~lm) | (bus_wdata & lm));
        3: m_iflg = 32'h0007_0000 & ((m_iflg & ~lm) | (m_iflg & bus_wdata & lm));
        4: begin
          m_fctl = 32'h001F_0000 & ((m_fctl & ~lm) | (bus_wdata & lm));
          rclr = m_fctl[16] && m_fctl[17];
          tclr = m_fctl[16] && m_fctl[18];
        end
        5: m_baud = 32'h03FF_0000 & ((m_baud & ~lm) | (bus_wdata & lm));
        8: tpush = bus_be[0];
        default: ;
      endcase
    end
    if (tpush && txf0)    m_stat[17] = 1'b1;
    if (rx_valid && rxf0) m_stat[16] = 1'b1;
    if (tclr) txq.delete();
    else begin
      if (tpop) void'(txq.pop_front());
      if (tpush && !txf0) txq.push_back(bus_wdata[7:0]);
    end
    if (rclr) rxq.delete();
    else begin
      if (rpop) void'(rxq.pop_front());
      if (rx_valid && !rxf0) rxq.push_back(rx_data);
    end
    if (rxne0) m_iflg[16] = 1'b1;
    if (txe0)  m_iflg[17] = 1'b1;
    m_irq = |(m_iflg & m_ien);
  endtask

  always @(posedge clk) model_step();

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (run && !done) begin
      chk("R1 rdata vs model", bus_rdata, m_rdata);
      chk("R6 irq vs model", {31'h0, irq}, {31'h0, m_irq});
      chk("R8 tx_valid vs model", {31'h0, tx_valid}, {31'h0, txq.size() != 0});
      if (tx_valid && txq.size() != 0) chk("R8 tx_data vs model", {24'h0, tx_data}, {24'h0, txq[0]});
    end
  end

  task automatic wr(input int ix, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_idx = 4'(ix); bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input int ix, input logic [3:0] be, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_idx = 4'(ix); bus_be = be;
    @(negedge clk);
    bus_sel = 0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; run = 1;
    repeat (2) @(negedge clk);
    // reset values
    rd(0, 4'hF, 32'h4000_0000, "R2 line control reset");
    rd(5, 4'hF, 32'h03FF_0000, "R2 baud reset");
    rd(4, 4'hF, 32'h0, "R2 fifo control reset");
    rd(2, 4'hF, 32'h0, "R2 enable reset");
    rd(1, 4'hF, 32'h0, "R2 status reset");
    chk("R2 tx_valid reset", {31'h0, tx_valid}, 32'h0);
    rd(3, 4'hF, 32'h0002_0000, "R5 tx empty flag after reset");
    rd(6, 4'hF, 32'h0, "R1 unmapped index");
    rd(8, 4'hF, 32'h0, "R1 transmit data reads zero");
    chk("R6 irq low with no enables", {31'h0, irq}, 32'h0);
    // masks and lanes
    wr(0, 4'hF, 32'hFFFF_FFFF);
    rd(0, 4'hF, 32'hE17F_0000, "R3 line control mask");
    wr(1, 4'hF, 32'hFFFF_FFFF);
    rd(1, 4'hF, 32'h0, "R3 status ignores writes");
    wr(5, 4'b0100, 32'h0);
    rd(5, 4'hF, 32'h0300_0000, "R3 baud single lane");
    wr(12, 4'hF, 32'hFFFF_FFFF);
    rd(12, 4'hF, 32'h0, "R3 receive data ignores writes");
    wr(2, 4'hF, 32'hFFFF_FFFF);
    chk("R6 irq on enabled tx-empty", {31'h0, irq}, 32'h1);
    rd(2, 4'hF, 32'h000F_0000, "R3 enable mask");
    wr(2, 4'hF, 32'h0002_0000);
    // transmit pushes
    wr(8, 4'b1110, 32'h0000_00AA);
    chk("R8 no push without low lane", {31'h0, tx_valid}, 32'h0);
    wr(8, 4'b0001, 32'h0000_0011);
    wr(8, 4'b0001, 32'h0000_0022);
    chk("R8 head byte", {24'h0, tx_data}, 32'h11);
    wr(3, 4'b0100, 32'h0);
    chk("R6 irq drops after clear", {31'h0, irq}, 32'h0);
    rd(3, 4'hF, 32'h0, "R4 zero clears flag");
    // receive bytes
    rx_byte(8'hA5);
    rx_byte(8'h5A);
    rd(3, 4'hF, 32'h0001_0000, "R5 rx ready flag");
    wr(3, 4'hF, 32'hFFFF_FFFF);
    rd(3, 4'hF, 32'h0001_0000, "R4 ones leave flag");
    wr(2, 4'hF, 32'h0001_0000);
    chk("R6 irq on enabled rx ready", {31'h0, irq}, 32'h1);
    rd(12, 4'b0111, 32'h0, "R9 no pop without top lane");
    rd(12, 4'hF, 32'hA500_0000, "R9 first byte");
    rd(12, 4'hF, 32'h5A00_0000, "R9 second byte");
    rd(12, 4'hF, 32'h0, "R9 empty reads zero");
    rd(3, 4'hF, 32'h0001_0000, "R5 rx flag sticky after empty");
    wr(3, 4'hF, 32'h0);
    rd(3, 4'hF, 32'h0, "R5 rx flag cleared");
    // drain transmit
    @(negedge clk); tx_ready = 1;
    @(negedge clk); chk("R8 second byte in order", {24'h0, tx_data}, 32'h22);
    @(negedge clk); chk("R8 drained", {31'h0, tx_valid}, 32'h0);
    tx_ready = 0;
    rd(3, 4'hF, 32'h0002_0000, "R5 tx empty flag after drain");
    // transmit overflow
    @(negedge clk);
    for (int i = 0; i < DEPTH + 1; i++) begin
      bus_sel = 1; bus_we = 1; bus_idx = 4'd8; bus_be = 4'b0001;
      bus_wdata = 32'h30 + 32'(i);
      @(negedge clk);
    end
    bus_sel = 0; bus_we = 0;
    rd(1, 4'hF, 32'h0002_0000, "R10 tx overflow bit");
    chk("R10 tx head kept", {24'h0, tx_data}, 32'h30);
    // receive overrun
    @(negedge clk);
    for (int i = 0; i < DEPTH + 1; i++) begin
      rx_valid = 1; rx_data = 8'(8'h40 + i);
      @(negedge clk);
    end
    rx_valid = 0;
    rd(1, 4'hF, 32'h0003_0000, "R10 rx overrun bit");
    rd(12, 4'hF, 32'h4000_0000, "R10 rx head kept");
    // flushes
    wr(4, 4'hF, 32'h0003_0000);
    rd(12, 4'hF, 32'h0, "R7 rx flushed");
    chk("R7 tx kept on rx flush", {31'h0, tx_valid}, 32'h1);
    wr(4, 4'hF, 32'h0005_0000);
    chk("R7 tx flushed", {31'h0, tx_valid}, 32'h0);
    rd(4, 4'hF, 32'h0005_0000, "R7 control bits kept");
    wr(8, 4'b0001, 32'h77);
    wr(4, 4'hF, 32'h0004_0000);
    chk("R7 no flush without enable", {31'h0, tx_valid}, 32'h1);
    // reset in operation
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R2 tx empty after reset", {31'h0, tx_valid}, 32'h0);
    rd(0, 4'hF, 32'h4000_0000, "R2 line control after reset");
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule